// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames into memory through a circular ring of descriptors that software prepares. Each descriptor takes four 32-bit words: the byte address of the next descriptor (offset 0), the byte address of its data buffer (offset 4), a command/status word (offset 8) and an extended status word (offset 12). The engine never touches the extended status word. Software gives a descriptor to the engine by clearing bit 31 of the command/status word and writing the buffer capacity in bytes into bits 11:0. The engine hands it back by writing a status word with bit 31 set.

After reset the engine waits for a start pulse. On the first pulse it takes its descriptor pointer from `ring_base`. It reads the command/status word first. If that descriptor is still owned by the engine, it reads the link and buffer words and then accepts bytes on a valid/ready stream. It packs the bytes little-endian into words and writes each word to the buffer. When a frame ends or the buffer fills, it writes the completion status and follows the link to the next descriptor. If it meets a descriptor it does not own, it goes idle. The next start pulse re-reads that same descriptor. A frame larger than its buffer continues into the following descriptors.

Memory accesses use one request/grant port. A request stays asserted and unchanged until it is granted. Read data is taken in the cycle of the grant.

Top module: `rxd_ring_engine`

## Requirements
- R1: After reset, and until the first `rx_start` pulse, `mem_req` and `in_ready` stay low whatever the byte stream does.
- R2: A descriptor fetch reads byte offset 8 (command/status) first, then offset 0 (link), then offset 4 (buffer pointer). The first fetch after reset uses `ring_base`.
- R3: If the command/status word read has bit 31 set, the engine goes idle with `mem_req` and `in_ready` low. A later `rx_start` re-reads the same descriptor.
- R4: Bytes fill consecutive buffer words from the buffer pointer, little-endian (the first byte lands in bits 7:0). A partial last word carries zeros in its unused lanes.
- R5: The completion status has bit 31 set and bit 29 clear. Bits 11:0 hold the number of bytes placed in this descriptor. On the final descriptor of a frame, bits 26:16 copy `in_flags[10:0]` as sampled with the last byte.
- R6: Bit 27 (packet OK) is set only on the final descriptor of a frame, and only when none of these flag bits is set: 26 abort, 25 overrun, 22 too long, 21 runt, 20 invalid symbol, 19 CRC, 18 alignment, 16 collision. Bits 24:23 (destination class) and 17 (loopback) do not clear it.
- R7: When a buffer fills (capacity is at least 1) before the frame ends, the engine writes status with bit 30 (MORE) set, size equal to the capacity, bit 27 and bits 26:16 clear. The frame then continues in the next descriptor.
- R8: The status word is written only after every data word of that descriptor, and no byte is accepted while a memory access is pending.
- R9: After each status write the engine follows the link word, so a ring whose last link points to the first wraps around.
- R10: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady from a request until its grant.
- R11: An `rx_start` pulse while the engine is not idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_start | input | 1 | Start / restart pulse |
| ring_base | input | AW | Byte address of the first descriptor |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | This byte ends the frame |
| in_flags | input | 11 | Receive condition flags, taken with the last byte (bit k maps to status bit 16+k) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request granted this cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |

## Verification
The assertions check these properties on every cycle:
- the request stays stable until its grant;
- no byte is accepted while memory is busy;
- the engine is silent before its first start;
- every status word written carries the ownership bit, respects the capacity, reports a full buffer when MORE is set, and never reports OK together with MORE or a bad flag.

Only the bench scenarios can show the order of the fetch reads, the byte packing, the ring wrap, the idle stop at an unowned descriptor (both between frames and in the middle of a frame), the resume on restart, and the fact that a start pulse while running changes nothing. The bench shows these by matching every granted transaction against a behavioural model under irregular grants.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int BYTE_LANES = 4;
    localparam int LANE_W     = $clog2(BYTE_LANES);
    localparam int SIZE_W     = 12;
    localparam int FLAG_W     = 11;
    localparam int WORD_W     = 32;

    localparam int OFS_LINK = 0;
    localparam int OFS_BUF  = 4;
    localparam int OFS_CTL  = 8;

    // flag bits (status bit 16+k) that make a frame bad
    localparam logic [FLAG_W-1:0] BAD_FLAGS = 11'h67D;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CTL,
        ST_RD_LINK,
        ST_RD_BUF,
        ST_RECV,
        ST_WR_DATA,
        ST_WR_STAT
    } eng_state_e;
endpackage

// File: rtl/rxd_lane_merge.sv
module rxd_lane_merge
    import rxd_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        byte_in,
    output logic [WORD_W-1:0] word_out
);
    for (genvar g = 0; g < BYTE_LANES; g++) begin : g_lane
        assign word_out[g*8 +: 8] = (lane == LANE_W'(g)) ? byte_in : word_in[g*8 +: 8];
    end
endmodule

// File: rtl/rxd_status_enc.sv
module rxd_status_enc
    import rxd_pkg::*;
(
    input  logic              more,
    input  logic [FLAG_W-1:0] flags,
    input  logic [SIZE_W-1:0] count,
    output logic [WORD_W-1:0] status
);
    logic              good;
    logic [FLAG_W-1:0] shown;

    always_comb begin
        shown  = more ? '0 : flags;
        good   = !more && ((flags & BAD_FLAGS) == '0);
        status = {1'b1, more, 1'b0, 1'b0, good, shown, 4'b0000, count};
    end
endmodule

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine
    import rxd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic [AW-1:0]     ring_base,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic [10:0]       in_flags,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata
);
    typedef struct packed {
        eng_state_e        st;
        logic [AW-1:0]     cur;
        logic [AW-1:0]     link;
        logic [AW-1:0]     bufp;
        logic [SIZE_W-1:0] cap;
        logic [SIZE_W-1:0] cnt;
        logic [WORD_W-1:0] word;
        logic [LANE_W-1:0] lane;
        logic              fin;
        logic [FLAG_W-1:0] flags;
        logic              loaded;
    } eng_t;

    eng_t q, d;

    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] stat_word;
    logic [SIZE_W-1:0] cnt_m1;
    logic [SIZE_W-1:0] cnt_p1;

    rxd_lane_merge u_merge (
        .word_in  (q.word),
        .lane     (q.lane),
        .byte_in  (in_data),
        .word_out (merged)
    );

    rxd_status_enc u_stat (
        .more   (!q.fin),
        .flags  (q.flags),
        .count  (q.cnt),
        .status (stat_word)
    );

    assign cnt_m1 = q.cnt - SIZE_W'(1);
    assign cnt_p1 = q.cnt + SIZE_W'(1);

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        in_ready  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (rx_start) begin
                    d.st     = ST_RD_CTL;
                    d.loaded = 1'b1;
                    if (!q.loaded) d.cur = ring_base;
                end
            end
            ST_RD_CTL: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + AW'(OFS_CTL);
                if (mem_gnt) begin
                    if (mem_rdata[31]) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.cap = mem_rdata[SIZE_W-1:0];
                        d.st  = ST_RD_LINK;
                    end
                end
            end
            ST_RD_LINK: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + AW'(OFS_LINK);
                if (mem_gnt) begin
                    d.link = mem_rdata[AW-1:0];
                    d.st   = ST_RD_BUF;
                end
            end
            ST_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + AW'(OFS_BUF);
                if (mem_gnt) begin
                    d.bufp = mem_rdata[AW-1:0];
                    d.cnt  = '0;
                    d.lane = '0;
                    d.word = '0;
                    d.st   = ST_RECV;
                end
            end
            ST_RECV: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.word = merged;
                    d.cnt  = cnt_p1;
                    d.lane = q.lane + LANE_W'(1);
                    if (in_last) begin
                        d.fin   = 1'b1;
                        d.flags = in_flags;
                    end
                    if (q.lane == LANE_W'(BYTE_LANES - 1) || in_last || cnt_p1 == q.cap)
                        d.st = ST_WR_DATA;
                end
            end
            ST_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.bufp + AW'({cnt_m1[SIZE_W-1:LANE_W], {LANE_W{1'b0}}});
                mem_wdata = q.word;
                if (mem_gnt) begin
                    d.word = '0;
                    d.lane = '0;
                    d.st   = (q.fin || q.cnt == q.cap) ? ST_WR_STAT : ST_RECV;
                end
            end
            ST_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.cur + AW'(OFS_CTL);
                mem_wdata = stat_word;
                if (mem_gnt) begin
                    d.cur   = q.link;
                    d.fin   = 1'b0;
                    d.flags = '0;
                    d.st    = ST_RD_CTL;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/rxd_ring_checker.sv
module rxd_ring_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_start,
    input logic          in_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_gnt,
    input logic [11:0]   cap_now,
    input logic [AW-1:0] cur_now
);
    logic started_q;
    logic stat_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started_q <= 1'b0;
        else if (rx_start) started_q <= 1'b1;
    end

    assign stat_wr = mem_req && mem_we && (mem_addr == cur_now + AW'(8));

    assert_silent_before_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !started_q |-> (!mem_req && !in_ready));

    assert_status_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |-> (mem_wdata[31] && !mem_wdata[29]));

    assert_ok_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && mem_wdata[27]) |-> (!mem_wdata[30] && ((mem_wdata[26:16] & 11'h67D) == 11'h000)));

    assert_more_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && mem_wdata[30]) |-> (mem_wdata[11:0] == cap_now && mem_wdata[26:16] == 11'h000));

    assert_size_in_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |-> (mem_wdata[11:0] != 12'd0 && mem_wdata[11:0] <= cap_now));

    assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !mem_req);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

bind rxd_ring_engine rxd_ring_checker #(.AW(AW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_start  (rx_start),
    .in_ready  (in_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .cap_now   (q.cap),
    .cur_now   (q.cur)
);

// File: tb/test_rxd_ring_engine.sv
`timescale 1ns/1ps
module test_rxd_ring_engine;
    localparam int BASE = 32'h100;
    localparam int BUF0 = 32'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic [10:0] in_flags = '0;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [0:4095];
    logic        b_we = 1'b0;
    logic [11:0] b_a = '0;
    logic [31:0] b_d = '0;
    logic [7:0]  lfsr;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    rxd_ring_engine #(.AW(32)) i_rxd_ring_engine (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .ring_base(BASE),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_flags(in_flags),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    // memory with irregular grants
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr <= 8'hA5;
        else lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    assign mem_gnt   = lfsr[0] | lfsr[3];
    assign mem_rdata = mem[mem_addr[13:2]];

    always @(posedge clk) begin
        if (b_we) mem[b_a] <= b_d;
        else if (mem_req && mem_we && mem_gnt) mem[mem_addr[13:2]] <= mem_wdata;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [64:0] exp_q[$];
    bit        own_hw [4];
    int        cap_m  [4];
    bit        m_loaded = 0;
    int        m_idx = 0;
    int        m_cnt, m_cap, m_lane;
    bit [31:0] m_word;

    function automatic int desc_addr(int i); return BASE + 16 * i; endfunction
    function automatic int buf_addr(int i);  return BUF0 + 1536 * i; endfunction

    function automatic void push_rd(int a); exp_q.push_back({1'b0, 32'(a), 32'h0}); endfunction
    function automatic void push_wr(int a, bit [31:0] v); exp_q.push_back({1'b1, 32'(a), v}); endfunction

    function automatic void model_fetch();
        push_rd(desc_addr(m_idx) + 8);
        if (!own_hw[m_idx]) begin
            push_rd(desc_addr(m_idx));
            push_rd(desc_addr(m_idx) + 4);
            m_cap = cap_m[m_idx]; m_cnt = 0; m_lane = 0; m_word = 0;
        end
    endfunction

    function automatic void model_start();
        if (!m_loaded) begin m_loaded = 1; m_idx = 0; end
        model_fetch();
    endfunction

    function automatic void model_byte(bit [7:0] b, bit last, bit [10:0] fl);
        bit [31:0] st;
        bit        ok;
        m_word[m_lane*8 +: 8] = b;
        m_cnt++; m_lane++;
        if (m_lane == 4 || last || m_cnt == m_cap) begin
            push_wr(buf_addr(m_idx) + ((m_cnt - 1) & ~3), m_word);
            m_word = 0; m_lane = 0;
            if (last || m_cnt == m_cap) begin
                ok = last && ((fl & 11'h67D) == 0);
                st = 32'h8000_0000 | 32'(m_cnt);
                if (last) st = st | (32'(fl) << 16) | (ok ? 32'h0800_0000 : 32'h0);
                else      st = st | 32'h4000_0000;
                push_wr(desc_addr(m_idx) + 8, st);
                own_hw[m_idx] = 1;
                m_idx = (m_idx + 1) % 4;
                model_fetch();
            end
        end
    endfunction

    // compare every granted transaction with the model, in order
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_gnt) begin
            bit [64:0] e;
            if (exp_q.size() == 0) begin
                check("R2 R8 R9 unexpected access", {31'b0, mem_we}, 32'hFFFF_FFFF);
            end else begin
                e = exp_q.pop_front();
                check("R2 R9 R10 access kind", {31'b0, mem_we}, {31'b0, e[64]});
                check("R2 R4 R9 R10 access address", mem_addr, e[63:32]);
                if (e[64]) check("R4 R5 R6 R7 R8 write data", mem_wdata, e[31:0]);
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic poke(input int byte_a, input logic [31:0] v);
        @(negedge clk); b_we = 1'b1; b_a = 12'(byte_a >> 2); b_d = v;
        @(negedge clk); b_we = 1'b0;
    endtask

    task automatic arm(input int i, input int cap);
        poke(desc_addr(i),     desc_addr((i + 1) % 4));
        poke(desc_addr(i) + 4, buf_addr(i));
        poke(desc_addr(i) + 12, 32'h0);
        poke(desc_addr(i) + 8, 32'(cap));
        own_hw[i] = 0; cap_m[i] = cap;
    endtask

    task automatic pulse_start(input bit modelled);
        @(negedge clk); rx_start = 1'b1;
        if (modelled) model_start();
        @(negedge clk); rx_start = 1'b0;
    endtask

    task automatic send_byte(input bit [7:0] b, input bit last, input bit [10:0] fl);
        logic r;
        model_byte(b, last, fl);
        in_valid = 1'b1; in_data = b; in_last = last; in_flags = fl;
        forever begin
            r = in_ready;
            @(negedge clk);
            if (r) break;
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic send_frame(input bit [7:0] first, input int n, input bit [10:0] fl);
        for (int k = 0; k < n; k++) send_byte(first + 8'(k), k == n - 1, fl);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic run();
        // R1: reset state and no reaction before start
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mem_req after reset", {31'b0, mem_req}, 32'h0);
        check("R1 in_ready after reset", {31'b0, in_ready}, 32'h0);
        for (int i = 0; i < 4; i++) arm(i, 1536);
        in_valid = 1'b1; in_data = 8'h55;
        repeat (5) @(negedge clk);
        check("R1 in_ready before start with valid", {31'b0, in_ready}, 32'h0);
        check("R1 mem_req before start", {31'b0, mem_req}, 32'h0);
        in_valid = 1'b0;

        // R2 R4 R5 R6: good frame of 10 bytes
        pulse_start(1);
        send_frame(8'hA0, 10, 11'h000);
        drain();
        check("R5 R6 status of good frame", mem[(desc_addr(0) + 8) >> 2], 32'h8800_000A);
        check("R4 first buffer word", mem[buf_addr(0) >> 2], 32'hA3A2_A1A0);
        check("R4 partial last word", mem[(buf_addr(0) + 8) >> 2], 32'h0000_A9A8);

        // R5 R6: CRC error plus destination class
        send_frame(8'hB0, 7, 11'h088);
        drain();
        check("R5 R6 status with CRC error", mem[(desc_addr(1) + 8) >> 2], 32'h8088_0007);

        // R6: destination class alone keeps OK
        send_frame(8'hC0, 4, 11'h100);
        drain();
        check("R6 status with class only", mem[(desc_addr(2) + 8) >> 2], 32'h8900_0004);

        // R3 R9: last slot, then wrap onto a descriptor not yet returned
        send_frame(8'hD0, 5, 11'h000);
        drain();
        check("R9 status after wrap slot", mem[(desc_addr(3) + 8) >> 2], 32'h8800_0005);
        repeat (20) @(negedge clk);
        check("R3 in_ready idle at unowned", {31'b0, in_ready}, 32'h0);
        check("R3 mem_req idle at unowned", {31'b0, mem_req}, 32'h0);

        // R7 R11: restart, frame spans a 6-byte buffer, start while busy
        arm(0, 6); arm(1, 1536); arm(2, 4);
        pulse_start(1);
        for (int k = 0; k < 9; k++) begin
            send_byte(8'hE0 + 8'(k), k == 8, 11'h000);
            if (k == 2) pulse_start(0);
        end
        drain();
        check("R7 MORE status on full buffer", mem[(desc_addr(0) + 8) >> 2], 32'hC000_0006);
        check("R4 R7 split word zero lanes", mem[(buf_addr(0) + 4) >> 2], 32'h0000_E5E4);
        check("R6 R7 tail status", mem[(desc_addr(1) + 8) >> 2], 32'h8800_0003);
        check("R4 R7 tail word", mem[buf_addr(1) >> 2], 32'h00E8_E7E6);
        check("R11 model drained after ignored start", 32'(exp_q.size()), 32'h0);

        // R3: stall in the middle of a frame, resume on start
        for (int k = 0; k < 4; k++) send_byte(8'hF0 + 8'(k), 1'b0, 11'h000);
        drain();
        repeat (20) @(negedge clk);
        check("R3 in_ready low mid-frame stall", {31'b0, in_ready}, 32'h0);
        check("R7 MORE status before stall", mem[(desc_addr(2) + 8) >> 2], 32'hC000_0004);
        arm(3, 1536);
        pulse_start(1);
        send_byte(8'hF4, 1'b0, 11'h000);
        send_byte(8'hF5, 1'b1, 11'h002);
        drain();
        check("R3 R6 resumed tail status", mem[(desc_addr(3) + 8) >> 2], 32'h8802_0002);
        check("R3 R4 resumed tail word", mem[buf_addr(3) >> 2], 32'h0000_F5F4);
        check("R9 all accesses seen", 32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (100000) @(posedge clk);
                total++; fails++;
                $display("FAIL R9 watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule